// File: doc/BRIEF.md
# Fractional Pacing Timer

This block produces a single-cycle tick whose average spacing is set by a divisor with an integer part and a fractional part. The tick paces the start of conversions in continuous mode: each interval lasts either 1 + INT or 2 + INT clock cycles. A first-order delta-sigma accumulator chooses which intervals are one cycle longer, so that the long-run average period is 1 + INT + FRAC/256 cycles.

The divisor fields arrive as static configuration inputs. A one-cycle `cfg_wr` strobe marks a change to either field and restarts both the cycle count and the accumulator. The count advances only while `run_en` is high; when it is low the count is frozen. An all-zero divisor turns pacing off. The block then raises `bypass`, which tells the consumer to start conversions back-to-back, and it emits no ticks. There is no data stream here: every pin is a plain control or status level.

Top module: `pace_timer`

## Requirements
- R1: After reset `tick` is 0, and `bypass` depends only on the divisor inputs.
- R2: `bypass` is 1 exactly when both `int_part` and `frac_part` are 0. While it is 1, `tick` stays 0 whatever `run_en` does.
- R3: After a restart, the first tick appears in the cycle that follows the (INT+1)-th clock edge at which `run_en` is high. The first interval is never extended.
- R4: Counting intervals from a restart as k = 0, 1, 2, ..., interval k lasts INT+2 cycles when floor((k+1)*FRAC/256) > floor(k*FRAC/256). Otherwise it lasts INT+1 cycles.
- R5: Over 256 consecutive intervals that start at a restart, exactly FRAC intervals are extended.
- R6: `tick` is high for one cycle per interval. When INT >= 1, it is never high in two consecutive cycles.
- R7: While `run_en` is 0, the count holds its value and `tick` stays 0. Counting resumes where it stopped.
- R8: An edge with `cfg_wr` = 1 restarts the count and the accumulator, takes priority over `run_en`, and leaves `tick` at 0 in the following cycle.
- R9: The full 16-bit integer range works: INT = 65535 with FRAC = 0 gives a first interval of 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Lets the count advance while high |
| cfg_wr | input | 1 | One-cycle strobe: a divisor field was written; restarts the divider |
| int_part | input | 16 | Integer part of the divisor |
| frac_part | input | 8 | Fractional part of the divisor, in 1/256 steps |
| tick | output | 1 | One-cycle pacing pulse |
| bypass | output | 1 | High when the divisor is zero and pacing is off |

## Verification
Random divisors with a small integer part and any fraction are each run for 256 intervals. Every interval is compared against the closed-form floor formula, which separates a faulty carry position from a wrong base length. The extended intervals are also counted against FRAC. Directed cases cover the following:
- FRAC of 1 and of 255 with INT = 0, where ticks may come in back-to-back cycles.
- The all-zero divisor.
- The largest integer part.
- A stall of `run_en` in the middle of an interval, which shows whether the count is held or reset.
- A write in the middle of a run with an accumulator phase that is not zero, which shows whether the accumulator is really cleared.

// File: rtl/pace_pkg.sv
package pace_pkg;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 8;
  localparam int CNT_W  = INT_W + 1;

  typedef logic [INT_W-1:0]  int_t;
  typedef logic [FRAC_W-1:0] frac_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/pace_dither.sv
// First-order delta-sigma stage: decides whether the current interval is long.
module pace_dither #(
  parameter int FW = pace_pkg::FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic [FW-1:0] frac,
  output logic          extend
);
  logic [FW-1:0] phase_q;
  logic          ext_q;
  logic [FW:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ext_q   <= 1'b0;
    end else if (restart) begin
      // interval 0: phase starts at zero, the add cannot carry
      phase_q <= frac;
      ext_q   <= 1'b0;
    end else if (advance) begin
      phase_q <= sum[FW-1:0];
      ext_q   <= sum[FW];
    end
  end

  assign extend = ext_q;
endmodule

// File: rtl/pace_count.sv
// Interval counter: signals the last cycle of each interval.
module pace_count #(
  parameter int IW = pace_pkg::INT_W,
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [IW-1:0] int_val,
  input  logic          extend,
  output logic          wrap
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = {1'b0, int_val} + {{(CW-1){1'b0}}, extend};
  assign wrap = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pace_timer.sv
module pace_timer
  import pace_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          cfg_wr,
  input  logic [IW-1:0] int_part,
  input  logic [FW-1:0] frac_part,
  output logic          tick,
  output logic          bypass
);
  logic run;
  logic wrap;
  logic extend;
  logic tick_q;

  assign bypass = (int_part == '0) && (frac_part == '0);
  assign run    = run_en && !bypass && !cfg_wr;

  pace_dither #(.FW(FW)) u_dither (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .advance (wrap),
    .frac    (frac_part),
    .extend  (extend)
  );

  pace_count #(.IW(IW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .run     (run),
    .int_val (int_part),
    .extend  (extend),
    .wrap    (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= wrap;
  end

  assign tick = tick_q;
endmodule

// File: rtl/pace_timer_chk.sv
module pace_timer_chk #(
  parameter int IW = 16,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          cfg_wr,
  input logic [IW-1:0] int_part,
  input logic [FW-1:0] frac_part,
  input logic          tick,
  input logic          bypass
);
  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(bypass)) |-> !tick);

  p_single_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && int_part != '0 && !cfg_wr) |=> (!tick || $changed(int_part)));

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cfg_wr) |=> !tick);

  p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !tick);

  p_tick_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run_en && !cfg_wr));
endmodule

bind pace_timer pace_timer_chk #(.IW(IW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr),
  .int_part(int_part), .frac_part(frac_part), .tick(tick), .bypass(bypass)
);

// File: tb/pace_timer_bench.sv
`timescale 1ns/1ps
module pace_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] int_part = '0;
  logic [7:0]  frac_part = '0;
  logic        tick;
  logic        bypass;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pace_timer u_pace_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr),
    .int_part(int_part), .frac_part(frac_part), .tick(tick), .bypass(bypass)
  );

  function automatic int ext_of(int k, int f);
    return (((k + 1) * f) / 256) - ((k * f) / 256);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic restart(int i, int f);
    int_part  = i[15:0];
    frac_part = f[7:0];
    cfg_wr    = 1'b1;
    step();
    cfg_wr    = 1'b0;
    chk(tick == 1'b0, "R8", tick, 0);
  endtask

  // run n intervals from a restart and compare each length
  task automatic run_intervals(int n, int i, int f, bit count_ext);
    int cnt = 0;
    int k = 0;
    int n_ext = 0;
    bit prev = 1'b0;
    run_en = 1'b1;
    while (k < n) begin
      step();
      cnt++;
      if (i >= 1) chk(!(prev && tick), "R6", 2, 1);
      prev = tick;
      if (tick) begin
        if (cnt == i + 2) n_ext++;
        chk(cnt == i + 1 + ext_of(k, f), (k == 0) ? "R3" : "R4", cnt, i + 1 + ext_of(k, f));
        k++;
        cnt = 0;
      end else if (cnt > i + 3) begin
        chk(1'b0, "R4", cnt, i + 1 + ext_of(k, f));
        k = n;
      end
    end
    if (count_ext) chk(n_ext == f, "R5", n_ext, f);
  endtask

  initial begin
    void'($urandom(32'd20241));
    // R1: reset state
    #1;
    chk(tick == 1'b0, "R1", tick, 0);
    chk(bypass == 1'b1, "R1", bypass, 1);
    step(); step();
    rst_n = 1'b1;
    step();
    chk(tick == 1'b0, "R1", tick, 0);

    // R2: zero divisor disables pacing
    restart(0, 0);
    chk(bypass == 1'b1, "R2", bypass, 1);
    run_en = 1'b1;
    for (int c = 0; c < 40; c++) begin
      step();
      chk(tick == 1'b0, "R2", tick, 0);
    end
    frac_part = 8'd1;
    #0.1;
    chk(bypass == 1'b0, "R2", bypass, 0);
    int_part = 16'd7; frac_part = 8'd0;
    #0.1;
    chk(bypass == 1'b0, "R2", bypass, 0);

    // directed corner fractions, R4 and R5
    restart(0, 1);   run_intervals(256, 0, 1, 1'b1);
    restart(0, 255); run_intervals(256, 0, 255, 1'b1);
    restart(3, 0);   run_intervals(256, 3, 0, 1'b1);

    // random divisors
    for (int t = 0; t < 6; t++) begin
      int ri = $urandom % 12;
      int rf = $urandom % 256;
      restart(ri, rf);
      run_intervals(256, ri, rf, 1'b1);
    end

    // R7: stall mid-interval holds the count
    restart(5, 0);
    run_en = 1'b1;
    for (int c = 0; c < 3; c++) begin step(); chk(tick == 1'b0, "R7", tick, 0); end
    run_en = 1'b0;
    for (int c = 0; c < 10; c++) begin step(); chk(tick == 1'b0, "R7", tick, 0); end
    run_en = 1'b1;
    step(); chk(tick == 1'b0, "R7", tick, 0);
    step(); chk(tick == 1'b0, "R7", tick, 0);
    step(); chk(tick == 1'b1, "R7", tick, 1);
    step(); chk(tick == 1'b0, "R6", tick, 0);

    // R8: write mid-run clears count and accumulator phase
    restart(4, 128);
    run_intervals(3, 4, 128, 1'b0);
    step(); step();
    restart(4, 128);
    run_intervals(4, 4, 128, 1'b0);

    // R9: full integer range
    restart(65535, 0);
    run_intervals(1, 65535, 0, 1'b0);

    run_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule